// File: doc/BRIEF.md
# SDRAM Read Turnaround Command Scheduler

This block sits in an SDRAM controller next to the command bus. It decides the cycle on which the next command may follow a read burst that is already running. It tracks the running burst as an age counter, which counts the cycles since the READ went out, together with the index of the last word the controller wants from that burst and whether the burst closes the row by itself. It accepts one pending request: READ, WRITE or PRECHARGE to the same bank. When the timing rules allow that request, it raises a one-cycle issue strobe with the command code. The controller places that command on the pins in the same cycle.

Reads chain with no gap: the next READ goes out CAS latency minus one cycles before the last wanted word appears, so its first word lands on the very next edge. A WRITE that cuts a read short first raises the output mask for three consecutive cycles. This blanks the unwanted read words, which appear two cycles after each mask cycle. The mask is then dropped in the WRITE cycle, so that the write data is not masked. An optional one-cycle bus turnaround gap covers boards where the write driver may turn on before the memory lets go of the bus.

A READ issued by this block starts a new burst inside the tracker. A READ issued elsewhere is announced on `rd_start`. CAS latency, burst length and the gap option are static configuration inputs.

Top module: `sdram_rd_turnaround`

## Requirements
- R1: While `rst_n` is low, `issue` and `dqm` are 0. After reset, and whenever no burst is active, a request is issued in the same cycle it is presented. Command codes: 1 = READ, 2 = WRITE, 3 = PRECHARGE, 0 = none.
- R2: Age counting works as follows. In the cycle of a READ (`rd_start` or an issued READ), the age is 0. Word k of that burst is valid at age CAS+k. A follow-on READ is issued no earlier than age last+1, where last is the last wanted index. This is CAS−1 cycles before the last wanted word.
- R3: A PRECHARGE for a burst without auto precharge is issued no earlier than age last+1.
- R4: A PRECHARGE is never issued while a burst started with auto precharge is active. A burst is active until age CAS+BL+1, or until a WRITE or PRECHARGE is issued.
- R5: A non-truncating WRITE (last = BL−1) is issued no earlier than age CAS+BL. With the gap option set, the earliest age is CAS+BL+1.
- R6: A truncating WRITE (last < BL−1) during an active burst is issued no earlier than age CAS+last+2. `dqm` is high in each of the 3 cycles before it and low in the WRITE cycle.
- R7: A request presented after its earliest age is issued in the cycle it arrives. The exception is a truncating WRITE, which is issued 3 cycles after it arrives, or at the end of the burst if that comes sooner.
- R8: On a WRITE, every read word that is not masked (masked when `dqm` was high two cycles earlier) is valid before the WRITE cycle. With the gap option set, there is at least one idle cycle between that word and the WRITE. No wanted word (index ≤ last) is ever masked.
- R9: An issued READ restarts the age at the next cycle with the request's own last index, so chained READs give gap-free data.
- R10: `issue_cmd` equals the request code on an issue and is 0 otherwise.
- R11: `dqm` is high only in the cycles in which a truncating WRITE waits for its mask lead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cas | input | 2 | CAS latency in cycles (1..MAX_CL) |
| cfg_burst | input | 4 | Burst length in words (1..MAX_BL) |
| cfg_gap | input | 1 | Insert idle cycle between read data and WRITE |
| rd_start | input | 1 | A READ was placed on the bus elsewhere this cycle |
| rd_last | input | 3 | Last wanted word index of that READ |
| rd_auto_pre | input | 1 | That READ uses auto precharge |
| req_valid | input | 1 | Pending request present (held until issued) |
| req_cmd | input | 2 | Pending command code |
| req_last | input | 3 | Last wanted index if the request is a READ |
| req_auto_pre | input | 1 | Auto precharge flag if the request is a READ |
| issue | output | 1 | Request goes out this cycle |
| issue_cmd | output | 2 | Command code being issued, 0 when idle |
| dqm | output | 1 | Output mask drive |

## Verification
The bench builds the block with its default limits: CAS latency up to 3 and bursts up to 8 words. This lets one build sweep CAS latencies 2 and 3 with burst lengths 2, 4 and 8. Every last-wanted index is covered, together with four request kinds, both gap settings and six arrival delays. The sweep therefore reaches early and late arrivals, writes that truncate and writes that do not, and auto-precharge bursts that run to their natural end. Chained READs at both latencies show that data stays gap-free. For each write, the bench replays the observed mask against the read word timing to rule out bus contention.

// File: rtl/sdrt_pkg.sv
// Package: shared command codes and the mask lead for the read
// turnaround scheduler. Assumes a 2-bit command field on the request port.
package sdrt_pkg;
    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_PRE   = 2'd3
    } sdrt_cmd_e;

    // Cycles of mask that must precede a truncating WRITE
    localparam int DQM_LEAD = 3;
endpackage

// File: rtl/sdrt_burst_track.sv
// Burst tracker: holds the age of the running read burst, its last wanted
// index and its auto-precharge flag. Age 0 is the READ cycle itself.
// Assumes start and close never occur in the same cycle.
module sdrt_burst_track #(
    parameter int AW  = 5,
    parameter int IW  = 3,
    parameter int CLW = 2,
    parameter int BLW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [IW-1:0]  start_last,
    input  logic           start_ap,
    input  logic           close,
    input  logic [CLW-1:0] cfg_cas,
    input  logic [BLW-1:0] cfg_burst,
    output logic [AW-1:0]  age_o,
    output logic [IW-1:0]  last_o,
    output logic           ap_o,
    output logic           active_o
);
    localparam logic [AW-1:0] AGE_MAX = '1;

    logic [AW-1:0] age_q;
    logic [IW-1:0] last_q;
    logic          ap_q;
    logic          live_q;
    logic          drained;

    // The burst counts as finished once the turnaround window has passed
    assign drained = age_q >= (AW'(cfg_cas) + AW'(cfg_burst) + AW'(1));

    // Age counter and descriptor capture on each new READ
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q  <= '0;
            last_q <= '0;
            ap_q   <= 1'b0;
            live_q <= 1'b0;
        end else if (start) begin
            age_q  <= AW'(1);
            last_q <= start_last;
            ap_q   <= start_ap;
            live_q <= 1'b1;
        end else begin
            if (age_q != AGE_MAX) begin
                age_q <= age_q + 1'b1;
            end
            if (close || drained) begin
                live_q <= 1'b0;
            end
        end
    end

    assign age_o    = age_q;
    assign last_o   = last_q;
    assign ap_o     = ap_q;
    assign active_o = live_q && !drained;

    // R9: a new READ restarts counting one cycle later
    p_age_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (age_q == AW'(1)));

    // R4: a drained burst no longer counts as active
    p_burst_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && drained && !start) |=> !live_q);
endmodule

// File: rtl/sdrt_turn_calc.sv
// Turnaround calculator: from CAS latency, burst length, gap option, last
// wanted index and current age, decides whether a READ/PRECHARGE or WRITE
// may go and whether the mask window for a truncating WRITE has opened.
// Purely combinational; assumes last < burst length.
module sdrt_turn_calc #(
    parameter int AW  = 5,
    parameter int IW  = 3,
    parameter int CLW = 2,
    parameter int BLW = 4
) (
    input  logic [CLW-1:0] cfg_cas,
    input  logic [BLW-1:0] cfg_burst,
    input  logic           cfg_gap,
    input  logic [IW-1:0]  last,
    input  logic [AW-1:0]  age,
    output logic           rd_ok,
    output logic           wr_due,
    output logic           trunc,
    output logic           dqm_win
);
    import sdrt_pkg::*;

    logic [AW-1:0] last_word_age;
    logic [AW-1:0] wr_age;

    // Age at which the last wanted word is valid
    assign last_word_age = AW'(cfg_cas) + AW'(last);

    // A WRITE truncates when wanted data ends before the burst does
    assign trunc = (AW'(last) + AW'(1)) < AW'(cfg_burst);

    // Earliest WRITE age: truncation leaves one masked word as the idle cycle
    always_comb begin
        if (trunc) begin
            wr_age = last_word_age + AW'(2);
        end else begin
            wr_age = last_word_age + AW'(1) + AW'(cfg_gap);
        end
    end

    // Follow-on READ/PRECHARGE: CAS-1 cycles ahead of the last wanted word
    assign rd_ok   = age > AW'(last);
    assign wr_due  = age >= wr_age;
    assign dqm_win = ({1'b0, age} + (AW+1)'(DQM_LEAD)) >= {1'b0, wr_age};
endmodule

// File: rtl/sdrt_dqm_gen.sv
// Mask generator: drives the output mask while a truncating WRITE waits and
// counts the consecutive mask cycles so the WRITE can see the lead is met.
// Assumes the waiting request stays valid until it is issued.
module sdrt_dqm_gen #(
    parameter int LEAD = 3,
    parameter int CW   = $clog2(LEAD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic win,
    output logic dqm,
    output logic lead_met
);
    logic [CW-1:0] run_q;

    assign dqm      = want && win;
    assign lead_met = run_q >= CW'(LEAD);

    // Count consecutive mask cycles, clear whenever the mask drops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (dqm) begin
            if (!lead_met) begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    // R6: the lead can only be met after the mask was driven
    p_lead_after_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_met && !$past(lead_met)) |-> $past(dqm));
endmodule

// File: rtl/sdram_rd_turnaround.sv
// Read turnaround command scheduler: issues a pending READ, WRITE or
// PRECHARGE on the first cycle the running read burst allows, and drives
// the output mask ahead of truncating WRITEs. The issue strobe is
// combinational so the command reaches the pins in the decided cycle.
// Assumes a single bank and a request held stable until issued.
module sdram_rd_turnaround #(
    parameter int MAX_CL = 3,
    parameter int MAX_BL = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(MAX_CL+1)-1:0] cfg_cas,
    input  logic [$clog2(MAX_BL+1)-1:0] cfg_burst,
    input  logic                        cfg_gap,
    input  logic                        rd_start,
    input  logic [$clog2(MAX_BL)-1:0]   rd_last,
    input  logic                        rd_auto_pre,
    input  logic                        req_valid,
    input  logic [1:0]                  req_cmd,
    input  logic [$clog2(MAX_BL)-1:0]   req_last,
    input  logic                        req_auto_pre,
    output logic                        issue,
    output logic [1:0]                  issue_cmd,
    output logic                        dqm
);
    import sdrt_pkg::*;

    localparam int CLW = $clog2(MAX_CL + 1);
    localparam int BLW = $clog2(MAX_BL + 1);
    localparam int IW  = $clog2(MAX_BL);
    localparam int AW  = $clog2(MAX_CL + MAX_BL + 4) + 1;

    logic [AW-1:0] age;
    logic [IW-1:0] last;
    logic          auto_pre;
    logic          active;
    logic          rd_ok;
    logic          wr_due;
    logic          trunc;
    logic          dqm_win;
    logic          lead_met;
    logic          allow;
    logic          go;
    logic          start;
    logic          close;
    logic          mask_want;
    logic [IW-1:0] start_last;
    logic          start_ap;
    logic          is_read;
    logic          is_write;
    logic          is_pre;

    assign is_read  = req_cmd == CMD_READ;
    assign is_write = req_cmd == CMD_WRITE;
    assign is_pre   = req_cmd == CMD_PRE;

    // Per-command permission given the running burst
    always_comb begin
        if (!active) begin
            allow = is_read || is_write || is_pre;
        end else if (is_read) begin
            allow = rd_ok;
        end else if (is_pre) begin
            allow = rd_ok && !auto_pre;
        end else if (is_write) begin
            allow = wr_due && (!trunc || lead_met);
        end else begin
            allow = 1'b0;
        end
    end

    assign go        = rst_n && req_valid && !rd_start && allow;
    assign start     = rd_start || (go && is_read);
    assign close     = go && (is_write || is_pre);
    assign start_last = rd_start ? rd_last : req_last;
    assign start_ap   = rd_start ? rd_auto_pre : req_auto_pre;
    assign mask_want = rst_n && active && req_valid && !rd_start &&
                       is_write && trunc && !go;

    assign issue     = go;
    assign issue_cmd = go ? req_cmd : CMD_NOP;

    sdrt_burst_track #(.AW(AW), .IW(IW), .CLW(CLW), .BLW(BLW)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_last (start_last),
        .start_ap   (start_ap),
        .close      (close),
        .cfg_cas    (cfg_cas),
        .cfg_burst  (cfg_burst),
        .age_o      (age),
        .last_o     (last),
        .ap_o       (auto_pre),
        .active_o   (active)
    );

    sdrt_turn_calc #(.AW(AW), .IW(IW), .CLW(CLW), .BLW(BLW)) u_calc (
        .cfg_cas   (cfg_cas),
        .cfg_burst (cfg_burst),
        .cfg_gap   (cfg_gap),
        .last      (last),
        .age       (age),
        .rd_ok     (rd_ok),
        .wr_due    (wr_due),
        .trunc     (trunc),
        .dqm_win   (dqm_win)
    );

    sdrt_dqm_gen #(.LEAD(DQM_LEAD)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .want     (mask_want),
        .win      (dqm_win),
        .dqm      (dqm),
        .lead_met (lead_met)
    );

    // R6: three mask cycles precede a truncating WRITE during a burst
    p_mask_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && is_write && active && trunc) |->
            ($past(dqm, 1) && $past(dqm, 2) && $past(dqm, 3)));

    // R6: mask is released in the cycle a command goes out
    p_mask_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !dqm);

    // R4: no PRECHARGE into an auto-precharge burst
    p_no_pre_auto_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && is_pre && active) |-> !auto_pre);

    // R8: a WRITE never lands on or before the last wanted word
    p_write_after_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && is_write && active) |-> (age > (AW'(cfg_cas) + AW'(last))));

    // R11: mask only while a WRITE request is waiting
    p_mask_needs_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dqm |-> (req_valid && is_write && !issue));

    // R10: nothing issued without a request
    p_issue_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (req_valid && issue_cmd != CMD_NOP));
endmodule

// File: tb/sdram_rd_turnaround_test.sv
module sdram_rd_turnaround_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_cas = 2'd2;
    logic [3:0] cfg_burst = 4'd4;
    logic       cfg_gap = 1'b0;
    logic       rd_start = 1'b0;
    logic [2:0] rd_last = '0;
    logic       rd_auto_pre = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_cmd = '0;
    logic [2:0] req_last = '0;
    logic       req_auto_pre = 1'b0;
    logic       issue;
    logic [1:0] issue_cmd;
    logic       dqm;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    sdram_rd_turnaround uut (
        .clk(clk), .rst_n(rst_n), .cfg_cas(cfg_cas), .cfg_burst(cfg_burst),
        .cfg_gap(cfg_gap), .rd_start(rd_start), .rd_last(rd_last),
        .rd_auto_pre(rd_auto_pre), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_last(req_last), .req_auto_pre(req_auto_pre), .issue(issue),
        .issue_cmd(issue_cmd), .dqm(dqm)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic do_reset(input int cl, input int bl, input int gap);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_cas = 2'(cl);
        cfg_burst = 4'(bl);
        cfg_gap = gap[0];
        req_valid = 1'b0;
        rd_start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // kind: 0 READ, 1 PRECHARGE, 2 PRECHARGE after auto-precharge burst, 3 WRITE
    task automatic trial(input int cl, input int bl, input int gap, input int lw,
                         input int kind, input int d);
        int  cmd;
        int  got;
        int  expi;
        int  base;
        int  wt;
        int  lo;
        bit  trunc;
        bit  bad;
        logic dh [0:63];
        for (int i = 0; i < 64; i++) dh[i] = 1'b0;
        cmd = (kind == 0) ? 1 : ((kind == 3) ? 2 : 3);
        do_reset(cl, bl, gap);
        @(negedge clk);
        rd_start = 1'b1;
        rd_last = 3'(lw);
        rd_auto_pre = (kind == 2);
        got = -1;
        for (int a = 1; a < 64; a++) begin
            @(negedge clk);
            rd_start = 1'b0;
            req_valid = (a >= d);
            req_cmd = 2'(cmd);
            req_last = '0;
            req_auto_pre = 1'b0;
            #1;
            dh[a] = dqm;
            if (issue) begin
                got = a;
                chk(issue_cmd == 2'(cmd), "R10 issue_cmd", int'(issue_cmd), cmd);
                break;
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        // Expected issue age from the requirements
        trunc = (kind == 3) && (lw < bl - 1);
        wt = trunc ? cl + lw + 2 : cl + lw + 1 + gap;
        case (kind)
            0, 1: begin base = lw + 1; expi = imax(d, base); end
            2: begin base = cl + bl + 1; expi = imax(d, base); end
            default: begin
                if (trunc) begin
                    base = wt;
                    expi = imin(imax(wt, d + 3), imax(d, cl + bl + 1));
                end else begin
                    base = cl + bl + gap;
                    expi = imax(d, base);
                end
            end
        endcase
        if (d > base) chk(got == expi, "R7 late request age", got, expi);
        else if (kind == 0) chk(got == expi, "R2 read age", got, expi);
        else if (kind == 1) chk(got == expi, "R3 precharge age", got, expi);
        else if (kind == 2) chk(got == expi, "R4 auto precharge hold", got, expi);
        else if (trunc) chk(got == expi, "R6 truncating write age", got, expi);
        else chk(got == expi, "R5 write age", got, expi);
        // Mask pattern
        lo = imax(wt - 3, d);
        bad = 1'b0;
        for (int a = 1; a <= got && a < 64; a++) begin
            if (dh[a] != (trunc && a >= lo && a <= got - 1 && a < cl + bl + 1)) bad = 1'b1;
        end
        chk(!bad, trunc ? "R6 dqm pattern" : "R11 dqm idle", int'(bad), 0);
        // Bus contention replay for writes
        if (kind == 3 && got > 0) begin
            bad = 1'b0;
            for (int k = 0; k < bl; k++) begin
                int  ag;
                bit  msk;
                ag = cl + k;
                msk = (ag >= 2) && (ag - 2 < 64) && dh[ag - 2];
                if (ag < got && !msk && ag > got - 1 - gap) bad = 1'b1;
                if (k <= lw && msk) bad = 1'b1;
            end
            chk(!bad, "R8 read/write contention", int'(bad), 0);
        end
    endtask

    task automatic chain(input int cl);
        int a1;
        int b1;
        do_reset(cl, 4, 0);
        @(negedge clk);
        rd_start = 1'b1;
        rd_last = 3'd3;
        rd_auto_pre = 1'b0;
        a1 = -1;
        for (int a = 1; a < 32; a++) begin
            @(negedge clk);
            rd_start = 1'b0;
            req_valid = 1'b1;
            req_cmd = 2'd1;
            req_last = 3'd1;
            #1;
            if (issue) begin a1 = a; break; end
        end
        b1 = -1;
        for (int b = 1; b < 32; b++) begin
            @(negedge clk);
            req_last = 3'd3;
            #1;
            if (issue) begin b1 = b; break; end
        end
        @(negedge clk);
        req_valid = 1'b0;
        // First word of each new burst lands right after the last wanted one
        chk(a1 + cl == cl + 3 + 1, "R9 chain gap-free first", a1 + cl, cl + 4);
        chk(b1 + cl == cl + 1 + 1, "R9 chain gap-free second", b1 + cl, cl + 2);
    endtask

    initial begin
        wait (cyc >= 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: quiet during reset, immediate issue when idle
        @(negedge clk);
        req_valid = 1'b1;
        req_cmd = 2'd1;
        #1;
        chk(issue == 1'b0, "R1 issue in reset", int'(issue), 0);
        chk(dqm == 1'b0, "R1 dqm in reset", int'(dqm), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(issue == 1'b1, "R1 idle issue", int'(issue), 1);
        chk(issue_cmd == 2'd1, "R10 idle cmd", int'(issue_cmd), 1);
        req_valid = 1'b0;
        #1;
        chk(issue_cmd == 2'd0, "R10 no request", int'(issue_cmd), 0);

        chain(2);
        chain(3);

        for (int cl = 2; cl <= 3; cl++) begin
            for (int bs = 0; bs < 3; bs++) begin
                int bl;
                bl = 2 << bs;
                for (int gap = 0; gap < 2; gap++) begin
                    for (int lw = 0; lw < bl; lw++) begin
                        for (int kind = 0; kind < 4; kind++) begin
                            for (int di = 0; di < 6; di++) begin
                                int d;
                                case (di)
                                    0: d = 1;
                                    1: d = 2;
                                    2: d = 3;
                                    3: d = 5;
                                    4: d = 8;
                                    default: d = 12;
                                endcase
                                trial(cl, bl, gap, lw, kind, d);
                            end
                        end
                    end
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule